// File: doc/BRIEF.md
# Start-Byte Addressed Serial Slave

This block is the serial front end of a display controller's register and memory port. An external master drives chip select, a serial clock and a data line; the slave answers on its own data line. All four serial signals are brought into the faster system clock domain through synchronizers, and their edges are detected there. Each transaction opens with an address byte that names the device, picks one of two targets with a register-select flag, and says whether the master writes or reads.

In a write, the bytes that follow are paired into 16-bit words, high byte first. Each word leaves the block as a one-clock strobe tagged with the register-select flag, aimed either at the index register or at the instruction/RAM-data path. In a read, the slave asks a response port for 16-bit words and shifts them out high byte first. Status reads return data from the first byte on. Instruction/RAM reads first return a fixed number of filler bytes. The register file and the memory behind the ports are outside this block.

Top module: `sbyte_serial_slave`

## Requirements
- R1: After reset, sdo_oe, wr_stb and rd_req are all 0.
- R2: The first byte after chip select falls is the address byte, shifted most significant bit first. Its top six bits must equal 0,1,1,1,0 followed by the level of id_strap. On a mismatch the rest of the transaction produces no wr_stb and no rd_req, and sdo_oe stays 0.
- R3: Address-byte bit 1 is RS and bit 0 is R/W (1 = read). RS=0 with R/W=0 writes words flagged wr_rs=0.
- R4: RS=1 with R/W=0 writes words flagged wr_rs=1.
- R5: In a write, the first byte of each pair is wr_data[15:8] and the second is wr_data[7:0]. wr_stb is a single-clock pulse, issued only after the second byte is complete.
- R6: One transaction carries any number of consecutive words, each giving its own strobe, in order.
- R7: RS=0 with R/W=1 reads status. The slave pulses rd_req with rd_rs=0 and shifts the returned word out high byte first, starting with the first byte after the address byte.
- R8: RS=1 with R/W=1 reads instruction or RAM data. The first four bytes after the address byte read as 0x00 and issue no rd_req. Returned words, flagged rd_rs=1, begin with the fifth byte.
- R9: Data is sampled on the rising edge of the serial clock. sdo changes after falling edges, so it is valid at the next rising edge. sdo_oe is 1 only during a matched read, and 0 again once chip select is high.
- R10: If chip select rises partway through a byte or a word, the partial data is dropped with no strobe. The next transaction starts clean.
- R11: rd_req is a one-clock pulse, issued when the previous word's last byte completes (or the address byte, or the last filler byte). A read that ends on a word boundary therefore leaves one request more than the words shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, idles high |
| sdi | input | 1 | Serial data from master |
| id_strap | input | 1 | Strap setting the last device-code bit |
| sdo | output | 1 | Serial data to master |
| sdo_oe | output | 1 | Drive enable for sdo (0 = high impedance) |
| wr_stb | output | 1 | One-clock write strobe |
| wr_rs | output | 1 | Register-select flag of the written word |
| wr_data | output | 16 | Written word |
| rd_req | output | 1 | One-clock request for the next read word |
| rd_rs | output | 1 | Register-select flag of the read request |
| rd_data | input | 16 | Read word, sampled in the clock after rd_req rises |

## Verification
The bench goes after the address byte with both strap levels, a wrong strap bit and a wrong fixed code. A slave that ignored the strap would accept a foreign transaction and emit strobes or drive the bus. It cuts transfers off inside a byte and between the two halves of a word. A design that kept the stale half would later emit a word built from one transaction's high byte and another's low byte. On instruction/RAM reads it counts the filler bytes and the requests they raise: a slave that skipped too few fillers, or none, would shift real data early and issue requests before the fifth byte. Every read byte is sampled just before a rising serial edge, so an output updated on the wrong edge shows up as shifted bits.

// File: rtl/ssl_pkg.sv
package ssl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WRITE,
    ST_READ,
    ST_IGNORE
  } ssl_state_e;

  // Fixed upper part of the device code; the last code bit comes from a strap.
  localparam logic [4:0] DEV_CODE_HI = 5'b01110;

endpackage

// File: rtl/ssl_sync.sv
module ssl_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[g] <= RST_VAL;
      else        stg[g] <= stg[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= stg[STAGES-1];
  end

  assign q    = stg[STAGES-1];
  assign rise = stg[STAGES-1] & ~prev_q;
  assign fall = ~stg[STAGES-1] & prev_q;

endmodule

// File: rtl/ssl_rx_shift.sv
module ssl_rx_shift #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          bit_en,
  input  logic          bit_in,
  output logic          byte_done,
  output logic [BW-1:0] byte_q
);

  localparam int CW = $clog2(BW);
  localparam logic [CW-1:0] LAST = CW'(BW - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] sr_q, sr_d;
  logic          done_d;
  logic [BW-1:0] byte_d;

  always_comb begin
    cnt_d  = cnt_q;
    sr_d   = sr_q;
    done_d = 1'b0;
    byte_d = byte_q;
    if (clr) begin
      cnt_d = '0;
    end else if (bit_en) begin
      sr_d = {sr_q[BW-2:0], bit_in};
      if (cnt_q == LAST) begin
        cnt_d  = '0;
        done_d = 1'b1;
        byte_d = {sr_q[BW-2:0], bit_in};
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      sr_q      <= '0;
      byte_done <= 1'b0;
      byte_q    <= '0;
    end else begin
      cnt_q     <= cnt_d;
      sr_q      <= sr_d;
      byte_done <= done_d;
      byte_q    <= byte_d;
    end
  end

endmodule

// File: rtl/ssl_tx_shift.sv
module ssl_tx_shift #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [BW-1:0] load_data,
  input  logic          shift_en,
  output logic          sdo
);

  logic [BW-1:0] sr_q, sr_d;
  logic          sdo_d;

  always_comb begin
    sr_d  = sr_q;
    sdo_d = sdo;
    if (clr) begin
      sr_d  = '0;
      sdo_d = 1'b0;
    end else if (load) begin
      sr_d = load_data;
    end else if (shift_en) begin
      sdo_d = sr_q[BW-1];
      sr_d  = {sr_q[BW-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      sdo  <= 1'b0;
    end else begin
      sr_q <= sr_d;
      sdo  <= sdo_d;
    end
  end

endmodule

// File: rtl/sbyte_serial_slave.sv
module sbyte_serial_slave
  import ssl_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DUMMY_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              id_strap,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              wr_stb,
  output logic              wr_rs,
  output logic [WORD_W-1:0] wr_data,
  output logic              rd_req,
  output logic              rd_rs,
  input  logic [WORD_W-1:0] rd_data
);

  localparam int BYTE_W = WORD_W / 2;
  localparam int SKW    = (DUMMY_BYTES > 0) ? $clog2(DUMMY_BYTES + 1) : 1;
  localparam logic [SKW-1:0] SKIP_INIT = SKW'(DUMMY_BYTES);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sq;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= 2'b00;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign srst_n = rst_sq[1];

  // Serial inputs into the system clock domain: {cs_n, sclk, sdi}.
  logic [2:0] pin_lvl, pin_rise, pin_fall;

  ssl_sync #(
    .W       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b110)
  ) i_sync (
    .clk  (clk),
    .rst_n(srst_n),
    .d    ({cs_n, sclk, sdi}),
    .q    (pin_lvl),
    .rise (pin_rise),
    .fall (pin_fall)
  );

  logic cs_lvl, cs_rise, cs_fall, sclk_rise, sclk_fall, sdi_lvl;
  assign cs_lvl    = pin_lvl[2];
  assign cs_rise   = pin_rise[2];
  assign cs_fall   = pin_fall[2];
  assign sclk_rise = pin_rise[1];
  assign sclk_fall = pin_fall[1];
  assign sdi_lvl   = pin_lvl[0];

  logic              byte_done;
  logic [BYTE_W-1:0] byte_q;

  ssl_rx_shift #(.BW(BYTE_W)) i_rx (
    .clk      (clk),
    .rst_n    (srst_n),
    .clr      (cs_fall),
    .bit_en   (sclk_rise & ~cs_lvl),
    .bit_in   (sdi_lvl),
    .byte_done(byte_done),
    .byte_q   (byte_q)
  );

  ssl_state_e        state_q, state_d;
  logic              rs_q, rs_d;
  logic [SKW-1:0]    skip_q, skip_d;
  logic              hi_q, hi_d;
  logic [BYTE_W-1:0] hold_q, hold_d;
  logic              load_req_q, load_req_d;
  logic              rd_req_q, rd_req_d;
  logic              wr_stb_q, wr_stb_d;
  logic [WORD_W-1:0] wr_data_q, wr_data_d;
  logic              tx_load;
  logic [BYTE_W-1:0] tx_data;
  logic              code_ok;

  assign code_ok = (byte_q[BYTE_W-1 -: 6] == {DEV_CODE_HI, id_strap});

  always_comb begin
    state_d    = state_q;
    rs_d       = rs_q;
    skip_d     = skip_q;
    hi_d       = hi_q;
    hold_d     = hold_q;
    load_req_d = 1'b0;
    rd_req_d   = 1'b0;
    wr_stb_d   = 1'b0;
    wr_data_d  = wr_data_q;
    tx_load    = 1'b0;
    tx_data    = '0;
    if (cs_rise) begin
      state_d = ST_IDLE;
    end else if (cs_fall) begin
      state_d = ST_ADDR;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (byte_done) begin
            if (code_ok) begin
              rs_d = byte_q[1];
              hi_d = 1'b1;
              if (byte_q[0]) begin
                state_d    = ST_READ;
                skip_d     = byte_q[1] ? SKIP_INIT : '0;
                load_req_d = 1'b1;
              end else begin
                state_d = ST_WRITE;
              end
            end else begin
              state_d = ST_IGNORE;
            end
          end
        end
        ST_WRITE: begin
          if (byte_done) begin
            if (hi_q) begin
              hold_d = byte_q;
              hi_d   = 1'b0;
            end else begin
              wr_stb_d  = 1'b1;
              wr_data_d = {hold_q, byte_q};
              hi_d      = 1'b1;
            end
          end
        end
        ST_READ: begin
          if (byte_done) load_req_d = 1'b1;
          if (load_req_q) begin
            if (skip_q != '0) begin
              tx_load = 1'b1;
              tx_data = '0;
              skip_d  = skip_q - 1'b1;
            end else if (hi_q) begin
              rd_req_d = 1'b1;
              hi_d     = 1'b0;
            end else begin
              tx_load = 1'b1;
              tx_data = hold_q;
              hi_d    = 1'b1;
            end
          end
          if (rd_req_q) begin
            tx_load = 1'b1;
            tx_data = rd_data[WORD_W-1:BYTE_W];
            hold_d  = rd_data[BYTE_W-1:0];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q    <= ST_IDLE;
      rs_q       <= 1'b0;
      skip_q     <= '0;
      hi_q       <= 1'b1;
      hold_q     <= '0;
      load_req_q <= 1'b0;
      rd_req_q   <= 1'b0;
      wr_stb_q   <= 1'b0;
      wr_data_q  <= '0;
    end else begin
      state_q    <= state_d;
      rs_q       <= rs_d;
      skip_q     <= skip_d;
      hi_q       <= hi_d;
      hold_q     <= hold_d;
      load_req_q <= load_req_d;
      rd_req_q   <= rd_req_d;
      wr_stb_q   <= wr_stb_d;
      wr_data_q  <= wr_data_d;
    end
  end

  ssl_tx_shift #(.BW(BYTE_W)) i_tx (
    .clk      (clk),
    .rst_n    (srst_n),
    .clr      (cs_fall),
    .load     (tx_load),
    .load_data(tx_data),
    .shift_en (sclk_fall && (state_q == ST_READ)),
    .sdo      (sdo)
  );

  assign sdo_oe  = (state_q == ST_READ);
  assign wr_stb  = wr_stb_q;
  assign wr_rs   = rs_q;
  assign wr_data = wr_data_q;
  assign rd_req  = rd_req_q;
  assign rd_rs   = rs_q;

endmodule

// File: rtl/ssl_chk.sv
module ssl_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sdo_oe,
  input logic wr_stb,
  input logic rd_req
);

  // R5
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R11
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  // R11
  rd_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> sdo_oe);

  // R9
  no_drive_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !sdo_oe);

  // R9
  release_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdo_oe);

endmodule

bind sbyte_serial_slave ssl_chk i_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .cs_n  (cs_n),
  .sdo_oe(sdo_oe),
  .wr_stb(wr_stb),
  .rd_req(rd_req)
);

// File: tb/test_sbyte_serial_slave.sv
module test_sbyte_serial_slave;

  localparam int HP = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, sclk, sdi, id_strap;
  logic        sdo, sdo_oe, wr_stb, wr_rs, rd_req, rd_rs;
  logic [15:0] wr_data, rd_data;

  always #10 clk = ~clk;

  sbyte_serial_slave i_sbyte_serial_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .id_strap(id_strap), .sdo(sdo), .sdo_oe(sdo_oe), .wr_stb(wr_stb),
    .wr_rs(wr_rs), .wr_data(wr_data), .rd_req(rd_req), .rd_rs(rd_rs),
    .rd_data(rd_data)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int rd_cnt  = 0;
  int wr_cnt  = 0;
  int oe_seen = 0;
  logic last_rd_rs = 1'b0;

  logic [16:0] exp_q[$];
  string       tag_q[$];

  // Response model: word k (1-based request count) = {tag, k}.
  assign rd_data = {rd_rs ? 8'hC3 : 8'h5A, 8'(rd_cnt)};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: counts requests and pops the write scoreboard.
  always @(negedge clk) begin
    if (rd_req) begin
      rd_cnt++;
      last_rd_rs = rd_rs;
    end
    if (sdo_oe) oe_seen++;
    if (wr_stb) begin
      wr_cnt++;
      if (exp_q.size() == 0) begin
        n_tests++;
        n_fail++;
        $display("FAIL R2/R10: actual unexpected write %0h expected none", {wr_rs, wr_data});
      end else begin
        check(tag_q.pop_front(), {15'd0, wr_rs, wr_data}, {15'd0, exp_q.pop_front()});
      end
    end
  end

  function automatic logic [7:0] addr_byte(input logic idb, input logic rs, input logic rw);
    return {5'b01110, idb, rs, rw};
  endfunction

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      sclk = 1'b0;
      sdi  = tx[i];
      repeat (HP) @(negedge clk);
      rx[i] = sdo;
      sclk = 1'b1;
      repeat (HP) @(negedge clk);
    end
  endtask

  task automatic cs_begin();
    oe_seen = 0;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_end();
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic write_words(input logic [7:0] ab, input logic [15:0] w[$], input int bits_last,
                             input bit expect_ok, input string tag);
    logic [7:0] rx;
    cs_begin();
    xfer(ab, 8, rx);
    foreach (w[i]) begin
      if (expect_ok && !(i == w.size() - 1 && bits_last < 8)) begin
        exp_q.push_back({ab[1], w[i]});
        tag_q.push_back(tag);
      end
      xfer(w[i][15:8], (i == w.size() - 1 && bits_last < 0) ? 0 : 8, rx);
      xfer(w[i][7:0], (i == w.size() - 1) ? ((bits_last < 0) ? 0 : bits_last) : 8, rx);
    end
    cs_end();
  endtask

  task automatic read_words(input logic rs, input int nwords);
    logic [7:0] rx, hi, lo;
    int base;
    cs_begin();
    base = rd_cnt;
    xfer(addr_byte(id_strap, rs, 1'b1), 8, rx);
    if (rs) begin
      for (int d = 0; d < 4; d++) begin
        xfer(8'h00, 8, rx);
        check("R8 filler byte", {24'd0, rx}, 32'h0);
      end
      check("R8 no request during fillers", rd_cnt - base, 1);
    end else begin
      check("R7 request after address byte", rd_cnt - base, 1);
    end
    for (int k = 1; k <= nwords; k++) begin
      xfer(8'h00, 8, hi);
      xfer(8'h00, 8, lo);
      check(rs ? "R8 read word" : "R7 read word", {16'd0, hi, lo},
            {16'd0, rs ? 8'hC3 : 8'h5A, 8'(base + k)});
    end
    check(rs ? "R8 rd_rs" : "R7 rd_rs", {31'd0, last_rd_rs}, {31'd0, rs});
    check("R11 request count", rd_cnt - base, nwords + 1);
    check("R9 sdo_oe during read", {31'd0, oe_seen > 0}, 32'd1);
    cs_end();
    check("R9 sdo_oe after chip select rises", {31'd0, sdo_oe}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int w0;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b1; sdi = 1'b0; id_strap = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 sdo_oe", {31'd0, sdo_oe}, 0);
    check("R1 wr_stb", {31'd0, wr_stb}, 0);
    check("R1 rd_req", {31'd0, rd_req}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R3 R5: index write, one word
    write_words(addr_byte(1'b0, 1'b0, 1'b0), '{16'h1234}, 8, 1, "R3 R5 index write");
    check("R9 no drive on write", oe_seen, 0);
    // R4 R6: three words in one transaction
    write_words(addr_byte(1'b0, 1'b1, 1'b0), '{16'hA55A, 16'h00FF, 16'hFE01}, 8, 1, "R4 R6 data write");
    // R2: strap set to 1
    id_strap = 1'b1;
    write_words(addr_byte(1'b1, 1'b1, 1'b0), '{16'h7E81}, 8, 1, "R2 strap-matched write");
    w0 = wr_cnt;
    write_words(addr_byte(1'b0, 1'b1, 1'b0), '{16'h1111}, 8, 0, "R2");
    check("R2 wrong strap bit: no write", wr_cnt - w0, 0);
    check("R2 wrong strap bit: bus not driven", oe_seen, 0);
    w0 = rd_cnt;
    write_words({5'b01111, 1'b1, 1'b1, 1'b1}, '{16'h2222}, 8, 0, "R2");
    check("R2 wrong code on read: no request", rd_cnt - w0, 0);
    check("R2 wrong code on read: bus not driven", oe_seen, 0);
    id_strap = 1'b0;

    // R7: status read, two words
    read_words(1'b0, 2);
    // R8: data read with fillers, three words
    read_words(1'b1, 3);

    // R10: abort inside a byte, then inside a word, then a clean write
    w0 = wr_cnt;
    write_words(addr_byte(1'b0, 1'b1, 1'b0), '{16'hABCD}, 5, 1, "R10");
    check("R10 abort mid-byte: no write", wr_cnt - w0, 0);
    write_words(addr_byte(1'b0, 1'b1, 1'b0), '{16'h9876}, 0, 1, "R10");
    check("R10 abort mid-word: no write", wr_cnt - w0, 0);
    write_words(addr_byte(1'b0, 1'b0, 1'b0), '{16'h0F0F, 16'h3C3C}, 3, 1, "R10 partial second word");
    check("R10 first word kept, partial dropped", wr_cnt - w0, 1);
    write_words(addr_byte(1'b0, 1'b1, 1'b0), '{16'hBEEF}, 8, 1, "R10 clean write after abort");
    check("R10 write after abort", wr_cnt - w0, 2);
    check("R6 scoreboard drained", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule